// File: doc/BRIEF.md
# Phased 64-bit Register Access Port

This block is the host-facing register port of a search-style device. A host reaches a small bank of 64-bit registers through a 32-bit data path, a 6-bit register address and four active-low strobes: enable, read/write direction, output enable and search. A free-running `phase` input splits every access into two clock cycles, a high-phase cycle followed by a low-phase cycle. In wide mode the two cycles carry the upper and lower halves of one 64-bit word. In narrow mode only the low-phase cycle writes, and it writes the lower half of the addressed register.

Reads follow the same ordering. The word sampled in a high-phase read cycle is the upper half of the register, and the word sampled in a low-phase cycle is the lower half. Both appear on the output one cycle after sampling. The pad tristate is driven by a registered enable, so a change of direction or output enable reaches the pins one cycle late. A completed write to the comparand register, with the search strobe low, produces a single-cycle search-start pulse for the match array. The match array itself lies outside this block.

Top module: `phased_reg_port`

## Requirements
- R1: After synchronous reset every register reads back as zero, and `dat_oe` and `search_start` are 0.
- R2: In wide mode (`mode64`=1), a write word sampled with `phase`=1 lands in bits 63:32 of the addressed register, and the word sampled with `phase`=0 lands in bits 31:0.
- R3: In wide mode the register changes only at the low-phase write edge. If a high-phase write is not followed by a low-phase write, the register keeps its old 64-bit value.
- R4: In narrow mode (`mode64`=0), a write with `phase`=0 updates bits 31:0 of the addressed register and leaves bits 63:32 unchanged. A write with `phase`=1 has no effect.
- R5: While `cen_n`=1 nothing is written, no search starts and `dat_oe` stays 0.
- R6: A read (`cen_n`=0, `rwn`=1) sampled with `phase`=1 puts bits 63:32 of the addressed register on `dat_o` for the next cycle. A read sampled with `phase`=0 puts bits 31:0 there.
- R7: `dat_oe` is 1 in the cycle after an edge that sampled `cen_n`=0, `rwn`=1 and `oe_n`=0, and is 0 otherwise. With `oe_n`=1 a read never enables the pad drivers.
- R8: `search_start` is 1 for exactly the one cycle after a completing write edge (`phase`=0) to address CMP_ADDR (default 0) that sampled `srch_n`=0. A write with `srch_n`=1, a write to another address, or a high-phase cycle alone gives no pulse.
- R9: Addresses at or above NREG (default 16) hold no register. Writes to them are dropped, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. All inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| phase | input | 1 | Access phase: 1 selects the upper half, 0 the lower half and completion |
| mode64 | input | 1 | 1 selects wide (64-bit) write mode, 0 selects narrow (32-bit) mode |
| cen_n | input | 1 | Active-low port enable |
| rwn | input | 1 | 1 selects a read, 0 selects a write |
| oe_n | input | 1 | Active-low output enable for read data |
| srch_n | input | 1 | Active-low search request, qualified by a comparand write |
| addr | input | 6 | Register address |
| dat_i | input | 32 | Data from the bus pads |
| dat_o | output | 32 | Read data to the bus pads |
| dat_oe | output | 1 | Registered pad drive enable for `dat_o` |
| search_start | output | 1 | Single-cycle search trigger |

## Verification
A corrupted staging register shows at the ports only after the next low-phase wide write, when a later read returns a wrong upper half. The bench therefore reads every written register back, both halves, in the two cycles right after the write completes. A register that updates at the wrong phase appears in a read-back after an aborted access, where the expected value is the old one. An error in the enable or search flops appears in the very next cycle, so those outputs are sampled one cycle after each stimulus edge and again one cycle later.

// File: rtl/phrp_pkg.sv
// Shared widths and types for the phased register port.
// Assumes a 32-bit bus, 64-bit registers and a 6-bit address.
package phrp_pkg;
    localparam int BUS_W  = 32;
    localparam int WORD_W = 2 * BUS_W;
    localparam int ADDR_W = 6;

    typedef logic [BUS_W-1:0]  half_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/phrp_stage.sv
// Half-word assembly. Holds the high-phase word of a wide write and
// presents a completed write during the low-phase cycle.
// Assumes the high-phase cycle precedes the low-phase cycle.
module phrp_stage
    import phrp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  phase,
    input  logic  mode64,
    input  logic  wr_act,
    input  half_t dat_i,
    output logic  wr_en,
    output logic  wr_full,
    output word_t wr_data
);
    half_t hi_q;

    // capture the upper half during a wide high-phase write
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_q <= '0;
        else if (wr_act && phase && mode64)
            hi_q <= dat_i;
    end

    // a write completes only in the low phase
    always_comb begin
        wr_en   = wr_act && !phase;
        wr_full = mode64;
        wr_data = {hi_q, dat_i};
    end
endmodule

// File: rtl/phrp_regfile.sv
// Bank of NREG 64-bit registers. A full write replaces the whole word,
// a partial write replaces the lower half only.
// Assumes addresses at or above NREG select nothing.
module phrp_regfile
    import phrp_pkg::*;
#(
    parameter int NREG = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  wr_full,
    input  addr_t                 addr,
    input  word_t                 wr_data,
    output logic [NREG-1:0][WORD_W-1:0] regs
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic hit;
        assign hit = (addr == ADDR_W'(g));

        // update one register when its address is written
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (wr_en && hit) begin
                regs[g][BUS_W-1:0] <= wr_data[BUS_W-1:0];
                if (wr_full)
                    regs[g][WORD_W-1:BUS_W] <= wr_data[WORD_W-1:BUS_W];
            end
        end
    end
endmodule

// File: rtl/phrp_rdpath.sv
// Read path: picks the half named by phase, registers it, and registers
// the pad drive enable so direction changes take one cycle.
// Assumes out-of-range addresses read as zero.
module phrp_rdpath
    import phrp_pkg::*;
#(
    parameter int NREG = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        phase,
    input  logic                        rd_act,
    input  logic                        oe_n,
    input  addr_t                       addr,
    input  logic [NREG-1:0][WORD_W-1:0] regs,
    output half_t                       dat_o,
    output logic                        dat_oe
);
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

    logic  in_range;
    word_t sel_word;
    half_t sel_half;

    // choose the addressed word and the half for this phase
    always_comb begin
        in_range = (int'(addr) < NREG);
        sel_word = in_range ? regs[addr[IDX_W-1:0]] : '0;
        sel_half = phase ? sel_word[WORD_W-1:BUS_W] : sel_word[BUS_W-1:0];
    end

    // register read data and the drive enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dat_o  <= '0;
            dat_oe <= 1'b0;
        end else begin
            dat_oe <= rd_act && !oe_n;
            if (rd_act)
                dat_o <= sel_half;
        end
    end
endmodule

// File: rtl/phrp_search.sv
// Search trigger: one-cycle pulse after a completed comparand write
// that carried the search request.
// Assumes wr_en is already qualified by enable, direction and phase.
module phrp_search
    import phrp_pkg::*;
#(
    parameter int CMP_ADDR = 0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  logic  srch_n,
    input  addr_t addr,
    output logic  search_start
);
    // raise the pulse for one cycle on a qualifying write
    always_ff @(posedge clk) begin
        if (!rst_n)
            search_start <= 1'b0;
        else
            search_start <= wr_en && !srch_n && (addr == ADDR_W'(CMP_ADDR));
    end
endmodule

// File: rtl/phased_reg_port.sv
// Top of the phased register port: decodes the strobes and wires the
// staging, register bank, read path and search trigger together.
// Assumes phase alternates high then low for each access.
module phased_reg_port
    import phrp_pkg::*;
#(
    parameter int NREG     = 16,
    parameter int CMP_ADDR = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        phase,
    input  logic        mode64,
    input  logic        cen_n,
    input  logic        rwn,
    input  logic        oe_n,
    input  logic        srch_n,
    input  logic [5:0]  addr,
    input  logic [31:0] dat_i,
    output logic [31:0] dat_o,
    output logic        dat_oe,
    output logic        search_start
);
    logic wr_act, rd_act, wr_en, wr_full;
    word_t wr_data;
    logic [NREG-1:0][WORD_W-1:0] regs;

    // strobe decode
    always_comb begin
        wr_act = !cen_n && !rwn;
        rd_act = !cen_n && rwn;
    end

    phrp_stage u_stage (
        .clk(clk), .rst_n(rst_n), .phase(phase), .mode64(mode64),
        .wr_act(wr_act), .dat_i(dat_i),
        .wr_en(wr_en), .wr_full(wr_full), .wr_data(wr_data)
    );

    phrp_regfile #(.NREG(NREG)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_full(wr_full),
        .addr(addr), .wr_data(wr_data), .regs(regs)
    );

    phrp_rdpath #(.NREG(NREG)) u_rd (
        .clk(clk), .rst_n(rst_n), .phase(phase), .rd_act(rd_act),
        .oe_n(oe_n), .addr(addr), .regs(regs),
        .dat_o(dat_o), .dat_oe(dat_oe)
    );

    phrp_search #(.CMP_ADDR(CMP_ADDR)) u_srch (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .srch_n(srch_n),
        .addr(addr), .search_start(search_start)
    );
endmodule

// File: rtl/phrp_chk.sv
// Port-level checker for the phased register port, bound to the top.
// Assumes synchronous active-low reset held from time zero.
module phrp_chk #(
    parameter int CMP_ADDR = 0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       phase,
    input logic       cen_n,
    input logic       rwn,
    input logic       oe_n,
    input logic       srch_n,
    input logic [5:0] addr,
    input logic       dat_oe,
    input logic       search_start
);
    // R7
    oe_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && rwn && !oe_n) |=> dat_oe);

    // R7
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rwn == 1'b0 || oe_n) |=> !dat_oe);

    // R5
    idle_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cen_n |=> (!dat_oe && !search_start));

    // R8
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        search_start |=> !search_start);

    // R8
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(search_start) |-> $past(!cen_n && !rwn && !srch_n && !phase
                                      && addr == 6'(CMP_ADDR)));
endmodule

bind phased_reg_port phrp_chk #(.CMP_ADDR(CMP_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .phase(phase), .cen_n(cen_n), .rwn(rwn),
    .oe_n(oe_n), .srch_n(srch_n), .addr(addr), .dat_oe(dat_oe),
    .search_start(search_start)
);

// File: tb/phased_reg_port_tb.sv
// Directed bench for the phased register port: one task per scenario.
module phased_reg_port_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phase = 1'b0, mode64 = 1'b1;
    logic        cen_n = 1'b1, rwn = 1'b1, oe_n = 1'b1, srch_n = 1'b1;
    logic [5:0]  addr = '0;
    logic [31:0] dat_i = '0;
    logic [31:0] dat_o;
    logic        dat_oe, search_start;

    logic [31:0] obs_o;
    logic        obs_oe, obs_ss;
    int checks = 0, errors = 0;
    logic done = 1'b0;

    phased_reg_port u_dut (
        .clk(clk), .rst_n(rst_n), .phase(phase), .mode64(mode64),
        .cen_n(cen_n), .rwn(rwn), .oe_n(oe_n), .srch_n(srch_n),
        .addr(addr), .dat_i(dat_i), .dat_o(dat_o), .dat_oe(dat_oe),
        .search_start(search_start)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one bus cycle: drive at the falling edge, observe just after the rising edge
    task automatic cyc(input logic ph, input logic cn, input logic rw, input logic oen,
                       input logic sn, input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        phase = ph; cen_n = cn; rwn = rw; oe_n = oen; srch_n = sn; addr = a; dat_i = d;
        @(posedge clk);
        #1;
        obs_o = dat_o; obs_oe = dat_oe; obs_ss = search_start;
    endtask

    task automatic idle();
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 6'd0, 32'h0);
    endtask

    task automatic wr64(input logic [5:0] a, input logic [63:0] v, input logic sn);
        cyc(1'b1, 1'b0, 1'b0, 1'b1, sn, a, v[63:32]);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, sn, a, v[31:0]);
    endtask

    task automatic rd64(input logic [5:0] a, output logic [63:0] v, output logic oe2);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, a, 32'h0);
        v[63:32] = obs_o; oe2 = obs_oe;
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, a, 32'h0);
        v[31:0] = obs_o; oe2 = oe2 & obs_oe;
    endtask

    task automatic t_reset();
        logic [63:0] v; logic oe2;
        chk("R1 dat_oe", {63'd0, obs_oe}, 64'd0);
        chk("R1 search_start", {63'd0, obs_ss}, 64'd0);
        rd64(6'd3, v, oe2);
        chk("R1 reg3 reads zero", v, 64'd0);
        idle();
    endtask

    task automatic t_wide();
        logic [63:0] v; logic oe2;
        mode64 = 1'b1;
        wr64(6'd2, 64'h11223344_55667788, 1'b1);
        rd64(6'd2, v, oe2);
        chk("R2 R6 wide write halves", v, 64'h11223344_55667788);
        chk("R7 oe during read", {63'd0, oe2}, 64'd1);
        idle();
        chk("R7 oe drops after read", {63'd0, obs_oe}, 64'd0);
    endtask

    task automatic t_atomic();
        logic [63:0] v; logic oe2;
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 6'd2, 32'hA5A5A5A5);
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 6'd2, 32'h5A5A5A5A);
        rd64(6'd2, v, oe2);
        chk("R3 aborted wide write keeps value", v, 64'h11223344_55667788);
        idle();
    endtask

    task automatic t_narrow();
        logic [63:0] v; logic oe2;
        wr64(6'd5, 64'h12345678_9ABCDEF0, 1'b1);
        mode64 = 1'b0;
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 6'd5, 32'hDEADBEEF);
        rd64(6'd5, v, oe2);
        chk("R4 high-phase narrow write ignored", v, 64'h12345678_9ABCDEF0);
        wr64(6'd5, 64'hDEADBEEF_0000CAFE, 1'b1);
        rd64(6'd5, v, oe2);
        chk("R4 narrow write lower half only", v, 64'h12345678_0000CAFE);
        mode64 = 1'b1;
        idle();
    endtask

    task automatic t_disabled();
        logic [63:0] v; logic oe2;
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 6'd5, 32'h01010101);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'd5, 32'h02020202);
        chk("R5 no search while disabled", {63'd0, obs_ss}, 64'd0);
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 6'd5, 32'h0);
        chk("R5 no drive while disabled", {63'd0, obs_oe}, 64'd0);
        rd64(6'd5, v, oe2);
        chk("R5 disabled write dropped", v, 64'h12345678_0000CAFE);
        idle();
    endtask

    task automatic t_oe();
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 6'd2, 32'h0);
        chk("R7 oe_n high blocks drive hi", {63'd0, obs_oe}, 64'd0);
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 6'd2, 32'h0);
        chk("R7 oe_n high blocks drive lo", {63'd0, obs_oe}, 64'd0);
        idle();
    endtask

    task automatic t_search();
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 6'd0, 32'hCAFEF00D);
        chk("R8 no pulse after high phase", {63'd0, obs_ss}, 64'd0);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd0, 32'h0BADBEEF);
        chk("R8 pulse after comparand write", {63'd0, obs_ss}, 64'd1);
        idle();
        chk("R8 pulse lasts one cycle", {63'd0, obs_ss}, 64'd0);
        wr64(6'd0, 64'h1, 1'b1);
        chk("R8 no pulse with srch_n high", {63'd0, obs_ss}, 64'd0);
        wr64(6'd1, 64'h2, 1'b0);
        chk("R8 no pulse for other address", {63'd0, obs_ss}, 64'd0);
        idle();
    endtask

    task automatic t_range();
        logic [63:0] v; logic oe2;
        wr64(6'd40, 64'hFFFF0000_FFFF0000, 1'b1);
        rd64(6'd40, v, oe2);
        chk("R9 out-of-range reads zero", v, 64'd0);
        rd64(6'd8, v, oe2);
        chk("R9 aliased register untouched", v, 64'd0);
        wr64(6'd15, 64'h0F0F0F0F_F0F0F0F0, 1'b1);
        rd64(6'd15, v, oe2);
        chk("R9 top valid register", v, 64'h0F0F0F0F_F0F0F0F0);
        idle();
    endtask

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        obs_o = dat_o; obs_oe = dat_oe; obs_ss = search_start;
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_wide();
        t_atomic();
        t_narrow();
        t_disabled();
        t_oe();
        t_search();
        t_range();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule